// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder on two separate ports. Two mode inputs choose the width of the dividend and whether the operands are two's-complement or unsigned. A 32-bit dividend comes in on two 16-bit words, a high word and a low word. In 16-bit mode only the low word is used. It is sign-extended in signed mode and zero-extended in unsigned mode.

The engine retires one quotient bit per clock over the full divisor width. After one setup cycle it runs 16 iteration cycles. Both dividend widths use the same datapath and the same latency. A caller raises `start` for one cycle while the block is idle, waits for the one-cycle `done` pulse, and then reads the results together with the divide-by-zero and overflow flags. Those values stay unchanged until the next accepted start.

Top module: `iter_divider`

## Requirements
- R1: A `start` sampled high while `busy` is low is accepted and `busy` is high from the next cycle until `done`. A `start` sampled while `busy` is high is ignored and does not alter the result.
- R2: `done` is high for exactly one cycle, 17 clock edges after the edge that accepted `start`, for both dividend widths. `busy` is low in that cycle.
- R3: In unsigned 32/16 mode (`wide`=1, `sgn`=0) the dividend is `{dd_hi,dd_lo}`, the quotient is the floor of dividend/divisor and the remainder is dividend minus quotient times divisor.
- R4: In unsigned 16/16 mode (`wide`=0, `sgn`=0) the dividend is `dd_lo` zero-extended, and `dd_hi` has no effect.
- R5: In signed mode the quotient is truncated toward zero. The remainder has the sign of the dividend (or is zero), and its magnitude is below the divisor's magnitude.
- R6: In signed 16/16 mode the dividend is `dd_lo` sign-extended from bit 15, and `dd_hi` has no effect.
- R7: A zero divisor raises `div_zero` together with `done` at the normal latency, and `ovf` is low. The quotient and remainder are then undefined.
- R8: `ovf` is raised with `done` when the true quotient lies outside 0..65535 (unsigned) or outside -32768..32767 (signed). The quotient and remainder are then undefined.
- R9: `quo`, `rem`, `div_zero` and `ovf` hold their values from `done` until the next accepted start, whatever happens on the operand inputs.
- R10: After reset `busy`, `done`, `div_zero` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (accepted when idle) |
| wide | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| sgn | input | 1 | 1: two's-complement operands, 0: unsigned |
| dd_hi | input | 16 | High word of the dividend |
| dd_lo | input | 16 | Low word of the dividend |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quo | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient out of range |

## Verification
Every result falls due 17 rising edges after the edge that samples `start`: one setup edge and then 16 iteration edges. The flags and the result words are valid from that point. The bench drives inputs on falling edges and counts rising edges from acceptance. At each of the first 16 edges it confirms that `done` is still low, expects `done` high after the 17th edge and low after the 18th, and reads the results only in the `done` cycle. For the hold case it reads them again several cycles later, after the operand inputs have been changed.

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         wide,
  input  logic         sgn,
  input  logic [W-1:0] dd_hi,
  input  logic [W-1:0] dd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_zero,
  output logic         ovf
);
  localparam int CW = $clog2(W);
  localparam int DW = 2 * W;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN} st_t;
  st_t st;

  logic [W-1:0]  a_hi, a_lo, a_dv;
  logic          a_wide, a_sgn;
  logic [W-1:0]  pr, sh, dm;
  logic          nq, nr, dz, povf, done_r;
  logic [CW-1:0] cnt;

  logic [DW-1:0] dd_full, dd_mag;
  logic [W-1:0]  dv_mag;
  logic          dd_neg, dv_neg;
  logic [W:0]    trial, diff;
  logic          fits, sovf;

  assign dd_full = a_wide ? {a_hi, a_lo}
                 : (a_sgn ? {{W{a_lo[W-1]}}, a_lo} : {{W{1'b0}}, a_lo});
  assign dd_neg  = a_sgn & dd_full[DW-1];
  assign dv_neg  = a_sgn & a_dv[W-1];
  assign dd_mag  = dd_neg ? (~dd_full + 1'b1) : dd_full;
  assign dv_mag  = dv_neg ? (~a_dv + 1'b1) : a_dv;

  assign trial = {pr, sh[W-1]};
  assign diff  = trial - {1'b0, dm};
  assign fits  = trial >= {1'b0, dm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_hi   <= '0;
      a_lo   <= '0;
      a_dv   <= '0;
      a_wide <= 1'b0;
      a_sgn  <= 1'b0;
      pr     <= '0;
      sh     <= '0;
      dm     <= '0;
      nq     <= 1'b0;
      nr     <= 1'b0;
      dz     <= 1'b0;
      povf   <= 1'b0;
      done_r <= 1'b0;
      cnt    <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            a_hi   <= dd_hi;
            a_lo   <= dd_lo;
            a_dv   <= dvs;
            a_wide <= wide;
            a_sgn  <= sgn;
            st     <= S_SETUP;
          end
        end
        S_SETUP: begin
          pr   <= dd_mag[DW-1:W];
          sh   <= dd_mag[W-1:0];
          dm   <= dv_mag;
          nq   <= dd_neg ^ dv_neg;
          nr   <= dd_neg;
          dz   <= (a_dv == '0);
          povf <= (a_dv != '0) && (dd_mag[DW-1:W] >= dv_mag);
          cnt  <= '0;
          st   <= S_RUN;
        end
        S_RUN: begin
          pr  <= fits ? diff[W-1:0] : trial[W-1:0];
          sh  <= {sh[W-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sovf     = a_sgn & (nq ? (sh > {1'b1, {(W-1){1'b0}}}) : sh[W-1]);
  assign busy     = (st != S_IDLE);
  assign done     = done_r;
  assign quo      = nq ? (~sh + 1'b1) : sh;
  assign rem      = nr ? (~pr + 1'b1) : pr;
  assign div_zero = dz;
  assign ovf      = ~dz & (povf | sovf);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !a_sgn && !div_zero && !ovf) |-> (rem < a_dv));
  p_zero_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> !ovf);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !done) |-> ($stable(quo) && $stable(rem) && $stable(ovf)));
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wide = 1'b0, sgn = 1'b0;
  logic [15:0] dd_hi = '0, dd_lo = '0, dvs = '0;
  logic        busy, done, div_zero, ovf;
  logic [15:0] quo, rem;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  iter_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .sgn(sgn),
    .dd_hi(dd_hi), .dd_lo(dd_lo), .dvs(dvs), .busy(busy), .done(done),
    .quo(quo), .rem(rem), .div_zero(div_zero), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(div_zero == 1'b0 && ovf == 1'b0, "R10 flags", {div_zero, ovf}, 0);
  endtask

  task automatic t_div(input string tag, input bit w, input bit s,
                       input logic [15:0] hi, input logic [15:0] lo,
                       input logic [15:0] dv, input bit poke);
    longint dd, dl, q, r;
    bit ez, eo;
    int early;
    dd = w ? (s ? longint'($signed({hi, lo})) : longint'({hi, lo}))
           : (s ? longint'($signed(lo)) : longint'(lo));
    dl = s ? longint'($signed(dv)) : longint'(dv);
    ez = (dl == 0);
    q = 0; r = 0; eo = 1'b0;
    if (!ez) begin
      q = dd / dl;
      r = dd % dl;
      eo = s ? (q < -32768 || q > 32767) : (q > 65535);
    end
    @(negedge clk);
    wide = w; sgn = s; dd_hi = hi; dd_lo = lo; dvs = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    early = 0;
    for (int k = 1; k <= 17; k++) begin
      if (poke && k == 5) begin
        start = 1'b1; dd_lo = lo ^ 16'h5a5a; dvs = dv ^ 16'h0013;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (k < 17 && done) early++;
    end
    chk(early == 0, {tag, " R2 no early done"}, early, 0);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R2 done at 17"}, {done, busy}, 2'b10);
    chk(div_zero == ez, {tag, " R7 div_zero"}, div_zero, ez);
    chk(ovf == eo, {tag, " R8 ovf"}, ovf, eo);
    if (!ez && !eo) begin
      chk(quo == q[15:0], {tag, " quotient"}, quo, q[15:0]);
      chk(rem == r[15:0], {tag, " remainder"}, rem, r[15:0]);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R2 single pulse"}, done, 0);
  endtask

  task automatic t_hold();
    logic [15:0] q0, r0;
    q0 = quo; r0 = rem;
    dd_hi = 16'hffff; dd_lo = 16'h1234; dvs = 16'h0001; sgn = ~sgn;
    repeat (4) @(negedge clk);
    chk(quo == q0 && rem == r0, "R9 hold", {quo, rem}, {q0, r0});
    chk(busy == 1'b0, "R9 idle", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div("R3 u32 basic", 1, 0, 16'h0001, 16'h2345, 16'h1234, 0);
    t_div("R3 u32 max", 1, 0, 16'hfffe, 16'hffff, 16'hffff, 0);
    t_div("R4 u16 hi ignored", 0, 0, 16'hbeef, 16'hfff1, 16'h0007, 0);
    t_div("R5 s neg/pos", 1, 1, 16'hffff, 16'hfff9, 16'h0002, 0);
    t_div("R5 s pos/neg", 1, 1, 16'h0000, 16'h0007, 16'hfffe, 0);
    t_div("R5 s neg/neg", 1, 1, 16'hffff, 16'hfff9, 16'hfffe, 0);
    t_div("R5 s32 large", 1, 1, 16'hfffe, 16'h7960, 16'h0007, 0);
    t_div("R6 s16 sext", 0, 1, 16'h1234, 16'h8000, 16'h0001, 0);
    t_div("R6 s16 neg", 0, 1, 16'h0000, 16'hff9c, 16'h0009, 0);
    t_div("R8 s16 min/-1", 0, 1, 16'h0000, 16'h8000, 16'hffff, 0);
    t_div("R8 s32 range", 1, 1, 16'hffff, 16'h8000, 16'hffff, 0);
    t_div("R8 u32 big", 1, 0, 16'h0001, 16'h0000, 16'h0001, 0);
    t_div("R7 zero", 1, 0, 16'h0012, 16'h3456, 16'h0000, 0);
    t_div("R1 start ignored", 1, 0, 16'h0003, 16'h9abc, 16'h4321, 1);
    t_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule